// File: doc/BRIEF.md
# Shared-Line Multi-Converter Readout Sequencer

This block runs the host side of a group of 16-bit successive-approximation converters. The converters share one convert-start line, one serial clock and one serial data line, and each has its own active-low select. A single trigger starts a scan. The sequencer raises the convert-start line with every select held high, so all converters sample together. It then waits a fixed conversion time and reads the converters one after another over the shared data line. Each converter drives the data line only while it is selected.

Every word is delivered with the index of its converter and a one-cycle valid strobe. After the last word the convert-start line drops and stays low for an acquisition window, and only then can the next trigger take effect. All timing is counted in system clocks. A parameter chooses whether each bit is sampled where the serial clock rises or just before it falls.

Top module: `adc_scan_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, cnv_o, sck_o, word_vld_o and busy_o are low and every sel_n_o bit is high.
- R2: A trigger seen high while the sequencer is idle raises cnv_o in the next cycle with all selects high. cnv_o then stays high for CONV_CLKS cycles before any select goes low, and it remains high until the last word is delivered.
- R3: At most one select is low at any time. Converters are read in index order 0, 1, up to N_DEV-1, and no select falls during the conversion window.
- R4: While a converter is selected, sck_o runs 16 periods, each HALF_CLKS cycles low followed by HALF_CLKS cycles high. sck_o is low whenever no select is low.
- R5: Words are assembled MSB first. The bit on the data line before any serial-clock fall becomes bit 15, and the bit after k falls becomes bit 15-k.
- R6: With SAMPLE_FALL=0 each bit is sampled in the cycle where sck_o rises. With SAMPLE_FALL=1 it is sampled in the cycle where sck_o falls. Both settings deliver the same words with the same timing.
- R7: After the 16th falling edge the select returns high, and all selects stay high for HALF_CLKS cycles before the next converter's select goes low.
- R8: word_vld_o is high for exactly one cycle, the cycle after the 16th falling edge of each converter. In that cycle word_o holds the word and word_idx_o holds the converter index.
- R9: busy_o is high from the cycle after the accepted trigger up to the last valid strobe, and it is low in the cycle of the last strobe.
- R10: After the last word, cnv_o stays low for at least ACQ_CLKS cycles. A trigger during a scan or during the acquisition window is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Starts a scan when seen high while idle |
| sdo_i | input | 1 | Shared serial data from the converters |
| cnv_o | output | 1 | Shared convert-start line |
| sck_o | output | 1 | Shared serial clock |
| sel_n_o | output | N_DEV | Active-low select, one per converter |
| word_o | output | WORD_BITS | Captured word |
| word_idx_o | output | IDX_W | Converter index of word_o |
| word_vld_o | output | 1 | One-cycle strobe for word_o |
| busy_o | output | 1 | Scan in progress |

## Verification
The hardest situation to reach from the ports is a trigger that lands in the acquisition window or in the first idle cycle after it. That boundary decides whether the trigger starts a scan or is dropped. The bench holds the trigger high across several scans, so the trigger is present in every acquisition cycle and in the first idle cycle. A behavioural converter model drives the shared data line, and the words are chosen to expose bit-order faults: all zeros, all ones, and single set bits at each end of the word. Two instances, one for each sample-edge setting, are compared against the same cycle-by-cycle expected stream.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_SHIFT,
    ST_GAP,
    ST_ACQ
  } scan_st_e;
endpackage

// File: rtl/adc_scan_timer.sv
// Loadable down-counter; holds at zero until reloaded.
module adc_scan_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/adc_scan_shifter.sv
// Serial capture register plus a count of serial-clock falls per word.
module adc_scan_shifter #(
  parameter int WORD_BITS   = 16,
  parameter bit SAMPLE_FALL = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 cap_i,
  input  logic                 fall_i,
  input  logic                 din_i,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 last_o
);
  localparam int FC_W = $clog2(WORD_BITS + 1);

  logic [WORD_BITS-1:0] sh_q, sh_d;
  logic [FC_W-1:0]      fall_q, fall_d;
  logic                 fall_en;

  always_comb begin
    sh_d    = {sh_q[WORD_BITS-2:0], din_i};
    fall_en = clr_i || fall_i;
    fall_d  = clr_i ? '0 : fall_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (cap_i) sh_q <= sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fall_q <= '0;
    else if (fall_en) fall_q <= fall_d;
  end

  assign last_o = (fall_q == FC_W'(WORD_BITS - 1));

  // With falling-edge capture the final bit arrives in the same cycle
  // as the last fall, so the word is taken from the shift input.
  generate
    if (SAMPLE_FALL) begin : g_fall
      assign word_o = sh_d;
    end else begin : g_rise
      assign word_o = sh_q;
    end
  endgenerate
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int N_DEV       = 3,
  parameter int WORD_BITS   = 16,
  parameter int CONV_CLKS   = 20,
  parameter int HALF_CLKS   = 2,
  parameter int ACQ_CLKS    = 6,
  parameter bit SAMPLE_FALL = 1'b0,
  localparam int IDX_W      = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 trig_i,
  input  logic                 sdo_i,
  output logic                 cnv_o,
  output logic                 sck_o,
  output logic [N_DEV-1:0]     sel_n_o,
  output logic [WORD_BITS-1:0] word_o,
  output logic [IDX_W-1:0]     word_idx_o,
  output logic                 word_vld_o,
  output logic                 busy_o
);
  localparam int MAX_A = (CONV_CLKS > ACQ_CLKS) ? CONV_CLKS : ACQ_CLKS;
  localparam int MAX_T = (MAX_A > HALF_CLKS) ? MAX_A : HALF_CLKS;
  localparam int TMR_W = $clog2(MAX_T + 1);

  scan_st_e             st_q, st_d;
  logic [IDX_W-1:0]     dev_q, dev_d;
  logic                 sck_q, sck_d;
  logic                 vld_q;
  logic [WORD_BITS-1:0] word_q;
  logic [IDX_W-1:0]     idx_q;

  logic                 t_load, t_zero;
  logic [TMR_W-1:0]     t_val;
  logic                 sh_clr, sh_cap, sh_fall, sh_last;
  logic [WORD_BITS-1:0] sh_word;
  logic                 out_ld;

  adc_scan_timer #(.CNT_W(TMR_W)) tmr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (t_load),
    .load_val_i (t_val),
    .zero_o     (t_zero)
  );

  adc_scan_shifter #(.WORD_BITS(WORD_BITS), .SAMPLE_FALL(SAMPLE_FALL)) shf_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (sh_clr),
    .cap_i  (sh_cap),
    .fall_i (sh_fall),
    .din_i  (sdo_i),
    .word_o (sh_word),
    .last_o (sh_last)
  );

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    dev_d   = dev_q;
    sck_d   = sck_q;
    t_load  = 1'b0;
    t_val   = TMR_W'(HALF_CLKS - 1);
    sh_clr  = 1'b0;
    sh_cap  = 1'b0;
    sh_fall = 1'b0;
    out_ld  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (trig_i) begin
          st_d   = ST_CONV;
          t_load = 1'b1;
          t_val  = TMR_W'(CONV_CLKS - 1);
          dev_d  = '0;
        end
      end
      ST_CONV: begin
        if (t_zero) begin
          st_d   = ST_SHIFT;
          t_load = 1'b1;
          sh_clr = 1'b1;
          sck_d  = 1'b0;
        end
      end
      ST_SHIFT: begin
        if (t_zero) begin
          t_load = 1'b1;
          if (!sck_q) begin
            sck_d  = 1'b1;
            sh_cap = !SAMPLE_FALL;
          end else begin
            sck_d   = 1'b0;
            sh_cap  = SAMPLE_FALL;
            sh_fall = 1'b1;
            if (sh_last) begin
              out_ld = 1'b1;
              if (dev_q == IDX_W'(N_DEV - 1)) begin
                st_d  = ST_ACQ;
                t_val = TMR_W'(ACQ_CLKS - 1);
              end else begin
                st_d  = ST_GAP;
                dev_d = dev_q + 1'b1;
              end
            end
          end
        end
      end
      ST_GAP: begin
        if (t_zero) begin
          st_d   = ST_SHIFT;
          t_load = 1'b1;
          sh_clr = 1'b1;
        end
      end
      ST_ACQ: begin
        if (t_zero) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      dev_q <= '0;
      sck_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      dev_q <= dev_d;
      sck_q <= sck_d;
      vld_q <= out_ld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      idx_q  <= '0;
    end else if (out_ld) begin
      word_q <= sh_word;
      idx_q  <= dev_q;
    end
  end

  // Outputs
  assign cnv_o      = (st_q == ST_CONV) || (st_q == ST_SHIFT) || (st_q == ST_GAP);
  assign busy_o     = cnv_o;
  assign sck_o      = sck_q;
  assign word_o     = word_q;
  assign word_idx_o = idx_q;
  assign word_vld_o = vld_q;

  generate
    for (genvar g = 0; g < N_DEV; g++) begin : g_sel
      assign sel_n_o[g] = !((st_q == ST_SHIFT) && (dev_q == IDX_W'(g)));
    end
  endgenerate
endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk #(
  parameter int N_DEV    = 3,
  parameter int IDX_W    = 2,
  parameter int ACQ_CLKS = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnv,
  input logic             sck,
  input logic [N_DEV-1:0] sel_n,
  input logic             vld,
  input logic [IDX_W-1:0] idx,
  input logic             busy
);
  int low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   low_cnt <= ACQ_CLKS;
    else if (cnv)                 low_cnt <= 0;
    else if (low_cnt < ACQ_CLKS)  low_cnt <= low_cnt + 1;
  end

  // R3
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~sel_n));

  // R2
  sel_cnv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (~sel_n != '0) |-> cnv);

  // R2
  rise_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv) |-> (&sel_n));

  // R4
  sck_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> (~sel_n != '0));

  // R8
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> !vld);

  // R7
  vld_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> (&sel_n));

  // R9
  busy_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && (idx == IDX_W'(N_DEV - 1))) |-> !busy);

  // R10
  acq_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv) |-> (low_cnt >= ACQ_CLKS));
endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk #(
  .N_DEV    (N_DEV),
  .IDX_W    (IDX_W),
  .ACQ_CLKS (ACQ_CLKS)
) chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .cnv   (cnv_o),
  .sck   (sck_o),
  .sel_n (sel_n_o),
  .vld   (word_vld_o),
  .idx   (word_idx_o),
  .busy  (busy_o)
);

// File: tb/adc_scan_ctrl_tb_top.sv
`timescale 1ns/1ps

// Behavioural converter group: the selected unit drives its word MSB first,
// advancing one bit per serial-clock fall; observed mid-cycle.
module adc_group_model #(
  parameter int N_DEV = 3,
  parameter int W     = 16
) (
  input  logic                    clk,
  input  logic [N_DEV-1:0]        sel_n,
  input  logic                    sck,
  input  logic [N_DEV-1:0][W-1:0] vals,
  output logic                    sdo
);
  int falls = 0;
  int dev   = 0;
  logic prev_sck = 1'b0;
  logic prev_idle = 1'b1;

  initial sdo = 1'b0;

  always @(negedge clk) begin
    if (&sel_n) begin
      falls = 0;
      sdo   = 1'b0;
    end else begin
      for (int d = 0; d < N_DEV; d++) if (!sel_n[d]) dev = d;
      if (prev_idle) falls = 0;
      else if (prev_sck && !sck) falls = falls + 1;
      sdo = (falls < W) ? vals[dev][W-1-falls] : 1'b0;
    end
    prev_sck  = sck;
    prev_idle = &sel_n;
  end
endmodule

module adc_scan_ctrl_tb_top;
  localparam int N_DEV = 3;
  localparam int W     = 16;
  localparam int CONV  = 20;
  localparam int HALF  = 2;
  localparam int ACQ   = 6;
  localparam int IDX_W = 2;

  typedef struct packed {
    logic             cnv;
    logic             sck;
    logic [N_DEV-1:0] sel_n;
    logic             vld;
    logic [W-1:0]     word;
    logic [IDX_W-1:0] idx;
    logic             busy;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0;
  logic [N_DEV-1:0][W-1:0] vals = '0;
  logic run_chk = 1'b0;

  int errors = 0;
  int checks = 0;
  int unsigned cyc = 0;

  logic sdo_r, sdo_f;
  logic cnv_r, sck_r, vld_r, busy_r;
  logic cnv_f, sck_f, vld_f, busy_f;
  logic [N_DEV-1:0] seln_r, seln_f;
  logic [W-1:0] word_r, word_f;
  logic [IDX_W-1:0] idx_r, idx_f;

  exp_t q[$];
  exp_t idle_e;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_scan_ctrl #(.N_DEV(N_DEV), .WORD_BITS(W), .CONV_CLKS(CONV), .HALF_CLKS(HALF),
                  .ACQ_CLKS(ACQ), .SAMPLE_FALL(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .sdo_i(sdo_r),
    .cnv_o(cnv_r), .sck_o(sck_r), .sel_n_o(seln_r), .word_o(word_r),
    .word_idx_o(idx_r), .word_vld_o(vld_r), .busy_o(busy_r));

  adc_scan_ctrl #(.N_DEV(N_DEV), .WORD_BITS(W), .CONV_CLKS(CONV), .HALF_CLKS(HALF),
                  .ACQ_CLKS(ACQ), .SAMPLE_FALL(1'b1)) dut_f_i (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .sdo_i(sdo_f),
    .cnv_o(cnv_f), .sck_o(sck_f), .sel_n_o(seln_f), .word_o(word_f),
    .word_idx_o(idx_f), .word_vld_o(vld_f), .busy_o(busy_f));

  adc_group_model #(.N_DEV(N_DEV), .W(W)) mdl_r (
    .clk(clk), .sel_n(seln_r), .sck(sck_r), .vals(vals), .sdo(sdo_r));
  adc_group_model #(.N_DEV(N_DEV), .W(W)) mdl_f (
    .clk(clk), .sel_n(seln_f), .sck(sck_f), .vals(vals), .sdo(sdo_f));

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", what, cyc, act, exp);
    end
  endtask

  // Expected timeline of one scan, starting the cycle after the trigger is taken.
  task automatic push_scan();
    exp_t e;
    e = '0; e.cnv = 1'b1; e.busy = 1'b1; e.sel_n = '1;
    repeat (CONV) q.push_back(e);                       // R2 conversion window
    for (int d = 0; d < N_DEV; d++) begin
      exp_t s;
      s = e; s.sel_n[d] = 1'b0;                         // R3 index order
      for (int b = 0; b < W; b++) begin
        s.sck = 1'b0; repeat (HALF) q.push_back(s);     // R4 low half
        s.sck = 1'b1; repeat (HALF) q.push_back(s);     // R4 high half
      end
      if (d < N_DEV - 1) begin
        for (int k = 0; k < HALF; k++) begin            // R7 release gap
          exp_t g;
          g = e;
          if (k == 0) begin g.vld = 1'b1; g.word = vals[d]; g.idx = IDX_W'(d); end
          q.push_back(g);
        end
      end else begin
        for (int k = 0; k < ACQ; k++) begin             // R10 acquisition
          exp_t a;
          a = idle_e;
          if (k == 0) begin a.vld = 1'b1; a.word = vals[d]; a.idx = IDX_W'(d); end
          q.push_back(a);
        end
      end
    end
  endtask

  task automatic cmp_dut(string nm, logic cnv, logic sck, logic [N_DEV-1:0] seln,
                         logic vld, logic [W-1:0] word, logic [IDX_W-1:0] idx,
                         logic busy, exp_t e, string wtag);
    chk({nm, " R2 R10 cnv"}, 64'(cnv), 64'(e.cnv));
    chk({nm, " R3 R7 sel_n"}, 64'(seln), 64'(e.sel_n));
    chk({nm, " R4 sck"}, 64'(sck), 64'(e.sck));
    chk({nm, " R8 vld"}, 64'(vld), 64'(e.vld));
    chk({nm, " R9 busy"}, 64'(busy), 64'(e.busy));
    if (e.vld) begin
      chk({nm, " ", wtag, " word"}, 64'(word), 64'(e.word));
      chk({nm, " R8 idx"}, 64'(idx), 64'(e.idx));
    end
  endtask

  always @(negedge clk) begin
    if (run_chk) begin
      exp_t e;
      logic idle_now;
      idle_now = (q.size() == 0);
      if (idle_now) e = idle_e;
      else e = q.pop_front();
      cmp_dut("dut_i", cnv_r, sck_r, seln_r, vld_r, word_r, idx_r, busy_r, e, "R5");
      cmp_dut("dut_f_i", cnv_f, sck_f, seln_f, vld_f, word_f, idx_f, busy_f, e, "R6");
      if (idle_now && trig) push_scan();
    end
  end

  task automatic drive_trig(int n);
    @(posedge clk); #1 trig = 1'b1;
    repeat (n) @(posedge clk);
    #1 trig = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (300) @(posedge clk);
  endtask

  initial begin
    idle_e = '0; idle_e.sel_n = '1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cnv in reset", 64'(cnv_r), 64'(0));
    chk("R1 sel_n in reset", 64'(seln_r), 64'({N_DEV{1'b1}}));
    chk("R1 busy in reset", 64'(busy_f), 64'(0));
    chk("R1 vld in reset", 64'(vld_r | vld_f), 64'(0));
    @(posedge clk); #1 rst_n = 1'b1; run_chk = 1'b1;
    repeat (4) @(posedge clk);

    vals[0] = 16'hA5C3; vals[1] = 16'h0000; vals[2] = 16'hFFFF;
    drive_trig(1);
    wait_idle();

    vals[0] = 16'h8001; vals[1] = 16'h7FFE; vals[2] = 16'h1234;
    drive_trig(700);          // R10 trigger held through busy and acquisition
    wait_idle();

    vals[0] = 16'hFFFF; vals[1] = 16'h0001; vals[2] = 16'h8000;
    drive_trig(1);
    repeat (120) @(posedge clk);
    drive_trig(3);            // R10 stray trigger mid-scan
    wait_idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc == 100000);
    checks++; errors++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule